// File: doc/BRIEF.md
# ARINC 429 Transmit Sequencer

This block takes 32-bit ARINC 429 words from a 16-bit host port and sends them as return-to-zero symbols. The host writes the lower half of a word first and the upper half second. The second write commits the word to a 32-deep queue. While the transmit enable is high, the sequencer takes words from the queue and sends each one LSB-first as a stream of line codes for an external line driver. Each bit is a data-level half followed by a null half, and a fixed word gap follows every word. Bit 32 can be sent as loaded, or it can be replaced by a parity bit whose sense is selectable.

A rate-select input chooses between two timings: fast (10 clocks per bit) and slow (80 clocks per bit). A free-running bit clock output runs at the matching division of the master clock. The host is given three registered flags: ready (the queue is drained and the last word has been sent), half full, and full. A test input forces the line to null whatever data is being sent.

Top module: `a429_tx_seq`

## Requirements
- R1: A word is loaded by a pulse on `wr_lo` (the value on `host_data` becomes bits 15:0) and then a pulse on `wr_hi` (the value on `host_data` becomes bits 31:16). The word is committed to the queue on the `wr_hi` cycle. Words are sent in the order they were written.
- R2: The queue holds 32 words. `full` is high while 32 words are held. A `wr_hi` while the queue is full is dropped, and no word from it is ever sent.
- R3: `half_full` is high while 16 or more words are held and low while fewer are held.
- R4: `line_code` uses 2'b00 for null, 2'b01 for a one and 2'b10 for a zero. Bits go out LSB first. Each bit is H cycles of its data level followed by H cycles of null. H is 5 when `slow_rate`=0 and 40 when `slow_rate`=1.
- R5: Between words sent back to back, the null half of bit 32 is followed by G more null cycles before bit 1 of the next word. G is 40 when `slow_rate`=0 and 320 when `slow_rate`=1.
- R6: With `par_en`=1, bit 32 is replaced by a parity bit over bits 1..31. The parity bit makes the count of ones in the 32-bit word odd when `par_even`=0 and even when `par_even`=1.
- R7: With `par_en`=0, all 32 loaded bits are sent unchanged.
- R8: `tx_ready` goes low in the cycle after a word is committed. It goes high again once bit 32 of a word has finished its null half and the queue is empty.
- R9: While `force_null` is high, `line_code` is null from the next cycle on. Sequencing continues underneath.
- R10: `bit_clk` is the master clock divided by 10 (`slow_rate`=0) or by 80 (`slow_rate`=1).
- R11: The first data level appears within 30 cycles of `tx_en` rising while words are queued. Queued words follow one another while `tx_en` stays high. A word already started is finished, but no new word starts while `tx_en` is low.
- R12: After reset the queue is empty, `line_code` is null, `tx_ready` is high, and `half_full` and `full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Host write data (one half of a word) |
| wr_lo | input | 1 | Latch the lower half of a word |
| wr_hi | input | 1 | Latch the upper half and commit the word |
| slow_rate | input | 1 | 0: fast timing, 1: slow timing |
| par_en | input | 1 | Replace bit 32 with parity |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| tx_en | input | 1 | Allow words to be started |
| force_null | input | 1 | Force the line to null |
| line_code | output | 2 | Line level code for the driver |
| bit_clk | output | 1 | Divided bit clock |
| tx_ready | output | 1 | Queue drained and last word sent |
| half_full | output | 1 | 16 or more words queued |
| full | output | 1 | 32 words queued |

## Verification
The hardest state to reach is the queue's boundary: 32 words held, an extra write that must vanish, and then all 32 words drained back to back. The stimulus fills the queue with `tx_en` low, so nothing drains during the fill. It then makes the extra write and only then enables transmission. Every word is captured from the line and compared, and each gap is measured. After the last word the line must stay null. A second hard case is dropping `tx_en` inside a word gap while a word is still queued. The line must stay null and `tx_ready` must stay low until `tx_en` is raised again.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    LC_NULL = 2'b00,
    LC_ONE  = 2'b01,
    LC_ZERO = 2'b10
  } line_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DATA,
    S_NULL,
    S_GAP
  } seq_t;
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int HALF  = DEPTH / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         accepted,
  output logic         empty,
  output logic         half_full,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_HALF = (AW+1)'(HALF);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count, count_nx;
  logic          do_push, do_pop;

  assign do_push  = push && (count != CNT_MAX);
  assign do_pop   = pop && (count != '0);
  assign accepted = do_push;
  assign empty    = (count == '0);

  always_comb begin
    count_nx = count;
    if (do_push && !do_pop) count_nx = count + 1'b1;
    else if (do_pop && !do_push) count_nx = count - 1'b1;
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    if (do_pop) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      half_full <= 1'b0;
      full      <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count     <= count_nx;
      half_full <= (count_nx >= CNT_HALF);
      full      <= (count_nx == CNT_MAX);
    end
  end
endmodule

// File: rtl/a429_tx_bitclk.sv
module a429_tx_bitclk #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_rate,
  output logic bit_clk
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DW   = $clog2(MAXD);
  localparam logic [DW-1:0] FAST_LAST = DW'(FAST_DIV - 1);
  localparam logic [DW-1:0] SLOW_LAST = DW'(SLOW_DIV - 1);
  localparam logic [DW-1:0] FAST_MID  = DW'(FAST_DIV / 2);
  localparam logic [DW-1:0] SLOW_MID  = DW'(SLOW_DIV / 2);

  logic [DW-1:0] cnt;
  logic [DW-1:0] last, mid;

  assign last = slow_rate ? SLOW_LAST : FAST_LAST;
  assign mid  = slow_rate ? SLOW_MID : FAST_MID;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
    end else begin
      cnt     <= (cnt >= last) ? '0 : cnt + 1'b1;
      bit_clk <= (cnt < mid);
    end
  end
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int W         = 32,
  parameter int FAST_HALF = 5,
  parameter int SLOW_HALF = 40,
  parameter int FAST_GAP  = 40,
  parameter int SLOW_GAP  = 320
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_en,
  input  logic         slow_rate,
  input  logic         par_en,
  input  logic         par_even,
  input  logic         force_null,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_rdata,
  output logic         pop,
  output logic         word_done,
  output logic [1:0]   line_code
);
  localparam int MG   = (SLOW_GAP > FAST_GAP) ? SLOW_GAP : FAST_GAP;
  localparam int MH   = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int MAXV = (MG > MH) ? MG : MH;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int BW   = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
  localparam logic [CW-1:0] FH = CW'(FAST_HALF);
  localparam logic [CW-1:0] SH = CW'(SLOW_HALF);
  localparam logic [CW-1:0] FG = CW'(FAST_GAP);
  localparam logic [CW-1:0] SG = CW'(SLOW_GAP);

  seq_t          st;
  logic [CW-1:0] cnt, half_len, gap_len;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg, loaded;
  logic          par_bit, can_start, half_end, gap_end;
  line_t         lc_q;

  assign par_bit   = (^fifo_rdata[W-2:0]) ^ ~par_even;
  assign loaded    = par_en ? {par_bit, fifo_rdata[W-2:0]} : fifo_rdata;
  assign can_start = tx_en && !fifo_empty;
  assign half_end  = (cnt == half_len - 1'b1);
  assign gap_end   = (cnt == gap_len - 2'd2);

  // the last gap cycle fetches the next word so the gap stays exact
  assign pop = ((st == S_IDLE) && can_start) || ((st == S_GAP) && gap_end && can_start);
  assign word_done = (st == S_NULL) && half_end && (bitn == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      half_len <= FH;
      gap_len  <= FG;
    end else begin
      case (st)
        S_IDLE: if (can_start) st <= S_FETCH;
        S_FETCH: begin
          shreg    <= loaded;
          half_len <= slow_rate ? SH : FH;
          gap_len  <= slow_rate ? SG : FG;
          cnt      <= '0;
          bitn     <= '0;
          st       <= S_DATA;
        end
        S_DATA: begin
          if (half_end) begin
            cnt <= '0;
            st  <= S_NULL;
          end else cnt <= cnt + 1'b1;
        end
        S_NULL: begin
          if (half_end) begin
            cnt <= '0;
            if (bitn == LAST_BIT) st <= S_GAP;
            else begin
              bitn  <= bitn + 1'b1;
              shreg <= shreg >> 1;
              st    <= S_DATA;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (gap_end) begin
            cnt <= '0;
            st  <= can_start ? S_FETCH : S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lc_q <= LC_NULL;
    else if (force_null || st != S_DATA) lc_q <= LC_NULL;
    else lc_q <= shreg[0] ? LC_ONE : LC_ZERO;
  end

  assign line_code = lc_q;
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 32,
  parameter int FAST_HALF = 5,
  parameter int SLOW_HALF = 40,
  parameter int FAST_GAP  = 40,
  parameter int SLOW_GAP  = 320
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W/2-1:0]   host_data,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic                  slow_rate,
  input  logic                  par_en,
  input  logic                  par_even,
  input  logic                  tx_en,
  input  logic                  force_null,
  output logic [1:0]            line_code,
  output logic                  bit_clk,
  output logic                  tx_ready,
  output logic                  half_full,
  output logic                  full
);
  localparam int HW = WORD_W / 2;

  logic [HW-1:0]     lo_hold;
  logic [WORD_W-1:0] rd_word;
  logic              accepted, empty, pop, word_done;

  always_ff @(posedge clk) begin
    if (rst) lo_hold <= '0;
    else if (wr_lo) lo_hold <= host_data;
  end

  a429_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH), .HALF(DEPTH / 2)) u_fifo (
    .clk(clk), .rst(rst),
    .push(wr_hi), .wdata({host_data, lo_hold}),
    .pop(pop), .rdata(rd_word),
    .accepted(accepted), .empty(empty),
    .half_full(half_full), .full(full)
  );

  a429_tx_ser #(
    .W(WORD_W), .FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF),
    .FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)
  ) u_ser (
    .clk(clk), .rst(rst), .tx_en(tx_en), .slow_rate(slow_rate),
    .par_en(par_en), .par_even(par_even), .force_null(force_null),
    .fifo_empty(empty), .fifo_rdata(rd_word),
    .pop(pop), .word_done(word_done), .line_code(line_code)
  );

  a429_tx_bitclk #(.FAST_DIV(2 * FAST_HALF), .SLOW_DIV(2 * SLOW_HALF)) u_bclk (
    .clk(clk), .rst(rst), .slow_rate(slow_rate), .bit_clk(bit_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_ready <= 1'b1;
    else if (accepted) tx_ready <= 1'b0;
    else if (word_done && empty) tx_ready <= 1'b1;
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_hi,
  input logic       force_null,
  input logic [1:0] line_code,
  input logic       tx_ready,
  input logic       half_full,
  input logic       full
);
  // R2
  full_has_half_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> half_full);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !full) |=> !tx_ready);

  // R9
  force_null_chk: assert property (@(posedge clk) disable iff (rst)
    force_null |=> (line_code == 2'b00));

  // R4
  rz_one_chk: assert property (@(posedge clk) disable iff (rst)
    (line_code == 2'b01) |=> (line_code != 2'b10));

  // R4
  rz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (line_code == 2'b10) |=> (line_code != 2'b01));
endmodule

bind a429_tx_seq a429_tx_chk u_chk (
  .clk(clk), .rst(rst), .wr_hi(wr_hi), .force_null(force_null),
  .line_code(line_code), .tx_ready(tx_ready),
  .half_full(half_full), .full(full)
);

// File: tb/sim_a429_tx_seq.sv
module sim_a429_tx_seq;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] host_data = '0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic        slow_rate = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic        tx_en = 1'b0, force_null = 1'b0;
  logic [1:0]  line_code;
  logic        bit_clk, tx_ready, half_full, full;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2) clk = ~clk;

  a429_tx_seq u0 (
    .clk(clk), .rst(rst), .host_data(host_data), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .slow_rate(slow_rate), .par_en(par_en), .par_even(par_even),
    .tx_en(tx_en), .force_null(force_null), .line_code(line_code),
    .bit_clk(bit_clk), .tx_ready(tx_ready), .half_full(half_full), .full(full)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk); host_data = w[15:0];  wr_lo = 1'b1;
    @(negedge clk); wr_lo = 1'b0; host_data = w[31:16]; wr_hi = 1'b1;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit pe, input bit ev);
    logic p;
    p = (^w[30:0]) ^ ~ev;
    return pe ? {p, w[30:0]} : w;
  endfunction

  // waits for the first data level; returns cycles waited
  task automatic wait_data(output int t);
    t = 0;
    @(negedge clk); t++;
    while (line_code == 2'b00 && t < 5000) begin @(negedge clk); t++; end
  endtask

  // current sample is the first data cycle of bit 1
  task automatic grab_word(input int h, output logic [31:0] w, output int bad);
    logic [1:0] c;
    bad = 0;
    w = '0;
    for (int b = 0; b < 32; b++) begin
      c = line_code;
      if (c == 2'b00 || c == 2'b11) bad++;
      w[b] = (c == 2'b01);
      for (int k = 1; k < h; k++) begin @(negedge clk); if (line_code != c) bad++; end
      for (int k = 0; k < h; k++) begin @(negedge clk); if (line_code != 2'b00) bad++; end
      if (b < 31) @(negedge clk);
    end
  endtask

  task automatic count_nulls(output int n);
    n = 0;
    @(negedge clk);
    while (line_code == 2'b00 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(line_code == 2'b00, "R12 line null", 32'(line_code), 0);
    chk(tx_ready == 1'b1, "R12 ready high", 32'(tx_ready), 1);
    chk(!half_full && !full, "R12 flags clear", {half_full, full}, 0);
  endtask

  task automatic t_single;
    logic [31:0] w; int t, bad;
    par_en = 1'b0;
    put_word(32'hA5C3_1E87);
    chk(tx_ready == 1'b0, "R8 ready falls on load", 32'(tx_ready), 0);
    @(negedge clk); tx_en = 1'b1;
    wait_data(t);
    chk(t <= 30, "R11 start latency", t, 30);
    grab_word(5, w, bad);
    chk(w == 32'hA5C3_1E87, "R1 R7 word order and content", w, 32'hA5C3_1E87);
    chk(bad == 0, "R4 fast bit timing", bad, 0);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R8 ready rises after last word", 32'(tx_ready), 1);
    tx_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_parity(input bit ev, input logic [31:0] din);
    logic [31:0] w, e; int t, bad;
    par_en = 1'b1; par_even = ev;
    e = expect_word(din, 1'b1, ev);
    put_word(din);
    @(negedge clk); tx_en = 1'b1;
    wait_data(t);
    grab_word(5, w, bad);
    chk(w == e, ev ? "R6 even parity" : "R6 odd parity", w, e);
    tx_en = 1'b0; par_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_fill_drain;
    logic [31:0] w, e; int t, bad, n, gbad, wbad;
    for (int i = 0; i < 15; i++) put_word(32'h1000_0000 + 32'(i) * 32'h0101_0101);
    chk(half_full == 1'b0, "R3 fifteen words", 32'(half_full), 0);
    put_word(32'h1000_0000 + 32'd15 * 32'h0101_0101);
    chk(half_full == 1'b1, "R3 sixteen words", 32'(half_full), 1);
    for (int i = 16; i < 31; i++) put_word(32'h1000_0000 + 32'(i) * 32'h0101_0101);
    chk(full == 1'b0, "R2 thirty-one words", 32'(full), 0);
    put_word(32'h1000_0000 + 32'd31 * 32'h0101_0101);
    chk(full == 1'b1, "R2 full at thirty-two", 32'(full), 1);
    put_word(32'hDEAD_BEEF);
    chk(full == 1'b1, "R2 full after dropped write", 32'(full), 1);
    @(negedge clk); tx_en = 1'b1;
    wait_data(t);
    gbad = 0; wbad = 0; bad = 0;
    for (int i = 0; i < 32; i++) begin
      int bb;
      if (i > 0) begin
        count_nulls(n);
        if (n != 40) gbad++;
      end
      grab_word(5, w, bb);
      bad += bb;
      e = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
      if (w != e) wbad++;
      if (i == 16) chk(half_full == 1'b0, "R3 below sixteen after drain", 32'(half_full), 0);
    end
    chk(wbad == 0, "R2 R11 thirty-two words in order", wbad, 0);
    chk(gbad == 0, "R5 fast word gap", gbad, 0);
    chk(bad == 0, "R4 fast bit timing in burst", bad, 0);
    n = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); if (line_code != 2'b00) n++; end
    chk(n == 0, "R2 dropped word never sent", n, 0);
    chk(tx_ready == 1'b1 && !full, "R8 ready after drain", {tx_ready, full}, 2);
    tx_en = 1'b0;
  endtask

  task automatic t_slow;
    logic [31:0] w; int t, bad, n;
    slow_rate = 1'b1;
    put_word(32'h0F0F_3C3C);
    put_word(32'h8421_0001);
    @(negedge clk); tx_en = 1'b1;
    wait_data(t);
    chk(t <= 240, "R11 slow start latency", t, 240);
    grab_word(40, w, bad);
    chk(w == 32'h0F0F_3C3C && bad == 0, "R4 slow first word", w, 32'h0F0F_3C3C);
    count_nulls(n);
    chk(n == 320, "R5 slow word gap", n, 320);
    grab_word(40, w, bad);
    chk(w == 32'h8421_0001 && bad == 0, "R4 slow second word", w, 32'h8421_0001);
    tx_en = 1'b0;
    repeat (400) @(negedge clk);
    slow_rate = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_bitclk(input bit slow, input int exp);
    int n; logic prev;
    slow_rate = slow;
    repeat (200) @(negedge clk);
    prev = bit_clk;
    @(negedge clk);
    while (!(bit_clk && !prev)) begin prev = bit_clk; @(negedge clk); end
    n = 0; prev = bit_clk;
    @(negedge clk); n++;
    while (!(bit_clk && !prev)) begin prev = bit_clk; @(negedge clk); n++; end
    chk(n == exp, slow ? "R10 slow bit clock" : "R10 fast bit clock", n, exp);
    slow_rate = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_force;
    int n;
    force_null = 1'b1;
    put_word(32'hFFFF_FFFF);
    @(negedge clk); tx_en = 1'b1;
    n = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); if (line_code != 2'b00) n++; end
    chk(n == 0, "R9 forced null line", n, 0);
    chk(tx_ready == 1'b1, "R9 word consumed under force", 32'(tx_ready), 1);
    tx_en = 1'b0; force_null = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_pause;
    logic [31:0] w; int t, bad, n;
    put_word(32'h1234_5678);
    put_word(32'h9ABC_DEF0);
    @(negedge clk); tx_en = 1'b1;
    wait_data(t);
    grab_word(5, w, bad);
    tx_en = 1'b0;
    chk(w == 32'h1234_5678, "R11 first word before pause", w, 32'h1234_5678);
    n = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (line_code != 2'b00) n++; end
    chk(n == 0, "R11 no start while disabled", n, 0);
    chk(tx_ready == 1'b0, "R8 ready low with word queued", 32'(tx_ready), 0);
    tx_en = 1'b1;
    wait_data(t);
    chk(t <= 30, "R11 restart latency", t, 30);
    grab_word(5, w, bad);
    chk(w == 32'h9ABC_DEF0, "R11 queued word after resume", w, 32'h9ABC_DEF0);
    tx_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_parity(1'b0, 32'h8000_0001);
    t_parity(1'b1, 32'h0000_0001);
    t_parity(1'b0, 32'h0000_0003);
    t_bitclk(1'b0, 10);
    t_bitclk(1'b1, 80);
    t_fill_drain();
    t_slow();
    t_force();
    t_pause();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule